// File: doc/BRIEF.md
# Transactional Line Ownership Controller

This block sits on the memory side of a shared store used by several processing elements, and it gives that store transactional behaviour. Memory is split into 32-byte lines. Each line holds two copies: a committed copy and a pending copy that takes uncommitted writes. Each line also carries an owner tag that names the transaction holding it. Every read or write request carries the transaction ID of the requester. The first access by a closed transaction opens it and gives it a start sequence number taken from a running counter.

When a transaction commits, the pending copies of all its lines become the committed copies in a single cycle, and its ownership is released. When a transaction aborts, its pending copies are dropped and the committed copies stay as they were. If a request touches a line owned by another transaction, the younger of the two transactions is rolled back. The younger one is the one with the higher start number. A failure input rolls back every transaction of one processing element at once.

Each request gets exactly one registered response in the following cycle.

Top module: `txn_line_owner`

## Requirements
- R1: After reset no line is owned, every committed copy reads as zero, and `rsp_valid` and `kill_valid` are low.
- R2: Every request cycle is followed, one cycle later, by exactly one response cycle with `rsp_tid` equal to the requesting ID. A cycle without a request is followed by no response. Request op codes: 0 read, 1 write, 2 commit, 3 abort. Response kinds: 1 data, 2 ack, 3 abort.
- R3: A read of a line the requester does not own returns the committed copy and claims the line. A write of such a line claims it, stores the full line in the pending copy only, and returns ack.
- R4: A read by the owning transaction returns its pending copy, including its own earlier writes.
- R5: A commit copies the pending copy of every line the transaction owns into the committed copy, all in one cycle. It releases those lines, closes the transaction and returns ack.
- R6: An abort command releases every line of the transaction, leaves the committed copies unchanged, closes the transaction and returns abort with the transaction's ID.
- R7: When a read or write hits a line owned by another transaction and the requester is younger, the requester is rolled back. The response is abort with the requester's ID, and the line keeps its owner.
- R8: When the requester is older than the owner, the owner is rolled back and reported on `kill_valid`/`kill_tid`. The request then proceeds on the committed copy.
- R9: A start number is assigned on the first read or write of a closed transaction, from a counter that increases by one per opening. A transaction opened again after closing is younger than every transaction still open. Every owned line belongs to an open transaction.
- R10: A failure pulse for element P, where transaction ID t belongs to element t / 2, rolls back all transactions of P and releases their lines. It produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 2 | 0 read, 1 write, 2 commit, 3 abort |
| req_tid | input | 2 | Transaction ID (element * 2 + slot) |
| req_line | input | 4 | Line index |
| req_wdata | input | 256 | Full line of write data |
| fail_valid | input | 1 | Element failure pulse |
| fail_pe | input | 1 | Failing element |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 2 | 1 data, 2 ack, 3 abort |
| rsp_tid | output | 2 | ID the response refers to |
| rsp_data | output | 256 | Line data for a data response, zero otherwise |
| kill_valid | output | 1 | An owning transaction was rolled back by an older requester |
| kill_tid | output | 2 | ID of that rolled-back owner |

## Verification
The checker assumes that a failure pulse and a request never arrive in the same cycle. It also assumes the start counter never wraps, because the age comparison is a plain unsigned compare. The bench keeps to the first assumption by giving each failure its own idle cycle. It keeps to the second by opening far fewer transactions than the counter range allows. Random traffic is concentrated on four lines so that conflicts in both directions are frequent. Directed sequences cover the reset state, commit, abort, reopening and failure.

// File: rtl/txn_pkg.sv
package txn_pkg;
    parameter int NUM_PE     = 2;
    parameter int TX_PER_PE  = 2;
    parameter int NUM_LINES  = 16;
    parameter int LINE_BYTES = 32;
    parameter int SEQ_W      = 16;

    localparam int NUM_TX = NUM_PE * TX_PER_PE;
    localparam int TID_W  = (NUM_TX > 1) ? $clog2(NUM_TX) : 1;
    localparam int PE_W   = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int DATA_W = LINE_BYTES * 8;

    typedef logic [TID_W-1:0]  tid_t;
    typedef logic [PE_W-1:0]   pe_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [NUM_TX-1:0] txmask_t;

    typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1,
                              OP_COMMIT = 2'd2, OP_ABORT = 2'd3} op_e;
    typedef enum logic [1:0] {RSP_NONE = 2'd0, RSP_DATA = 2'd1,
                              RSP_ACK = 2'd2, RSP_ABORT = 2'd3} rsp_e;

    typedef struct packed {
        logic  conflict;
        logic  req_loses;
        logic  victim;
        logic  grant;
    } verdict_t;

    function automatic txmask_t tid_bit(tid_t t);
        txmask_t m;
        m = '0;
        m[t] = 1'b1;
        return m;
    endfunction

    function automatic txmask_t pe_mask(pe_t pe);
        txmask_t m;
        for (int t = 0; t < NUM_TX; t++)
            m[t] = ((t / TX_PER_PE) == int'(pe));
        return m;
    endfunction
endpackage

// File: rtl/txn_seq_table.sv
module txn_seq_table
    import txn_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    open_en,
    input  tid_t    open_tid,
    input  txmask_t close_mask,
    output txmask_t open_q,
    output seq_t    seq_q [NUM_TX],
    output seq_t    next_seq
);
    logic fresh;
    assign fresh = open_en && !open_q[open_tid];

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= '0;
            next_seq <= '0;
            for (int t = 0; t < NUM_TX; t++) seq_q[t] <= '0;
        end else begin
            if (fresh) begin
                seq_q[open_tid] <= next_seq;
                next_seq        <= next_seq + seq_t'(1);
            end
            open_q <= (open_q | (fresh ? tid_bit(open_tid) : '0)) & ~close_mask;
        end
    end
endmodule

// File: rtl/txn_resolve.sv
module txn_resolve
    import txn_pkg::*;
(
    input  logic     mem_req,
    input  tid_t     req_tid,
    input  logic     own_vld,
    input  tid_t     own_tid,
    input  txmask_t  open_q,
    input  seq_t     seq_q [NUM_TX],
    input  seq_t     next_seq,
    output verdict_t verdict
);
    seq_t req_seq;
    seq_t own_seq;

    always_comb begin
        req_seq           = open_q[req_tid] ? seq_q[req_tid] : next_seq;
        own_seq           = seq_q[own_tid];
        verdict.conflict  = mem_req && own_vld && (own_tid != req_tid);
        verdict.req_loses = verdict.conflict && (req_seq > own_seq);
        verdict.victim    = verdict.conflict && !verdict.req_loses;
        verdict.grant     = mem_req && !verdict.req_loses;
    end
endmodule

// File: rtl/txn_line_store.sv
module txn_line_store
    import txn_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    acc_en,
    input  logic    acc_write,
    input  line_t   acc_line,
    input  tid_t    acc_tid,
    input  data_t   acc_wdata,
    input  txmask_t rel_mask,
    input  logic    cmt_en,
    input  tid_t    cmt_tid,
    output data_t   rd_active,
    output data_t   rd_update,
    output logic    rd_own_vld,
    output tid_t    rd_own_tid,
    output logic [NUM_LINES-1:0]       own_vld_q,
    output logic [NUM_LINES*TID_W-1:0] own_flat
);
    data_t active_q [NUM_LINES];
    data_t update_q [NUM_LINES];
    tid_t  own_tid_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            own_vld_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) begin
                active_q[i]  <= '0;
                update_q[i]  <= '0;
                own_tid_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (cmt_en && own_vld_q[i] && own_tid_q[i] == cmt_tid) begin
                    active_q[i]  <= update_q[i];
                    own_vld_q[i] <= 1'b0;
                end else if (own_vld_q[i] && rel_mask[own_tid_q[i]]) begin
                    own_vld_q[i] <= 1'b0;
                end
                if (acc_en && acc_line == line_t'(i)) begin
                    own_vld_q[i] <= 1'b1;
                    own_tid_q[i] <= acc_tid;
                    if (acc_write)
                        update_q[i] <= acc_wdata;
                    else if (!(own_vld_q[i] && own_tid_q[i] == acc_tid))
                        update_q[i] <= active_q[i];
                end
            end
        end
    end

    assign rd_active  = active_q[acc_line];
    assign rd_update  = update_q[acc_line];
    assign rd_own_vld = own_vld_q[acc_line];
    assign rd_own_tid = own_tid_q[acc_line];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_flat
        assign own_flat[g*TID_W +: TID_W] = own_tid_q[g];
    end
endmodule

// File: rtl/txn_line_owner.sv
module txn_line_owner
    import txn_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [TID_W-1:0]    req_tid,
    input  logic [LINE_W-1:0]   req_line,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                fail_valid,
    input  logic [PE_W-1:0]     fail_pe,
    output logic                rsp_valid,
    output logic [1:0]          rsp_kind,
    output logic [TID_W-1:0]    rsp_tid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                kill_valid,
    output logic [TID_W-1:0]    kill_tid
);
    op_e      op;
    logic     mem_req, is_commit, self_rel;
    verdict_t verdict;
    txmask_t  rel_mask, close_mask, open_w;
    seq_t     seq_w [NUM_TX];
    seq_t     next_seq_w;
    data_t    rd_active, rd_update;
    logic     rd_own_vld;
    tid_t     rd_own_tid;
    logic [NUM_LINES-1:0]       own_vld_w;
    logic [NUM_LINES*TID_W-1:0] own_flat_w;
    rsp_e     kind_d;
    data_t    data_d;

    assign op        = op_e'(req_op);
    assign mem_req   = req_valid && (op == OP_READ || op == OP_WRITE);
    assign is_commit = req_valid && (op == OP_COMMIT);
    assign self_rel  = (req_valid && op == OP_ABORT) || verdict.req_loses;

    always_comb begin
        rel_mask = '0;
        if (self_rel)       rel_mask = rel_mask | tid_bit(req_tid);
        if (verdict.victim) rel_mask = rel_mask | tid_bit(rd_own_tid);
        if (fail_valid)     rel_mask = rel_mask | pe_mask(fail_pe);
        close_mask = rel_mask | (is_commit ? tid_bit(req_tid) : '0);
    end

    txn_seq_table u_seq (
        .clk(clk), .rst(rst),
        .open_en(verdict.grant), .open_tid(req_tid),
        .close_mask(close_mask),
        .open_q(open_w), .seq_q(seq_w), .next_seq(next_seq_w)
    );

    txn_resolve u_res (
        .mem_req(mem_req), .req_tid(req_tid),
        .own_vld(rd_own_vld), .own_tid(rd_own_tid),
        .open_q(open_w), .seq_q(seq_w), .next_seq(next_seq_w),
        .verdict(verdict)
    );

    txn_line_store u_store (
        .clk(clk), .rst(rst),
        .acc_en(verdict.grant), .acc_write(op == OP_WRITE),
        .acc_line(req_line), .acc_tid(req_tid), .acc_wdata(req_wdata),
        .rel_mask(rel_mask), .cmt_en(is_commit), .cmt_tid(req_tid),
        .rd_active(rd_active), .rd_update(rd_update),
        .rd_own_vld(rd_own_vld), .rd_own_tid(rd_own_tid),
        .own_vld_q(own_vld_w), .own_flat(own_flat_w)
    );

    always_comb begin
        kind_d = RSP_NONE;
        data_d = '0;
        if (req_valid) begin
            case (op)
                OP_READ: begin
                    kind_d = verdict.req_loses ? RSP_ABORT : RSP_DATA;
                    if (!verdict.req_loses)
                        data_d = (rd_own_vld && rd_own_tid == req_tid) ? rd_update : rd_active;
                end
                OP_WRITE:  kind_d = verdict.req_loses ? RSP_ABORT : RSP_ACK;
                OP_COMMIT: kind_d = RSP_ACK;
                default:   kind_d = RSP_ABORT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_kind   <= RSP_NONE;
            rsp_tid    <= '0;
            rsp_data   <= '0;
            kill_valid <= 1'b0;
            kill_tid   <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_kind   <= kind_d;
            rsp_tid    <= req_tid;
            rsp_data   <= data_d;
            kill_valid <= verdict.victim;
            kill_tid   <= rd_own_tid;
        end
    end
endmodule

// File: rtl/txn_owner_checker.sv
module txn_owner_checker
    import txn_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic [1:0]                 req_op,
    input logic [TID_W-1:0]           req_tid,
    input logic                       fail_valid,
    input logic [PE_W-1:0]            fail_pe,
    input logic                       rsp_valid,
    input logic [1:0]                 rsp_kind,
    input logic [TID_W-1:0]           rsp_tid,
    input logic                       kill_valid,
    input logic [TID_W-1:0]           kill_tid,
    input logic [NUM_LINES-1:0]       own_vld,
    input logic [NUM_LINES*TID_W-1:0] own_flat,
    input logic [NUM_TX-1:0]          open_q
);
    function automatic logic owned_in(logic [NUM_TX-1:0] m);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_LINES; i++)
            if (own_vld[i] && m[own_flat[i*TID_W +: TID_W]]) r = 1'b1;
        return r;
    endfunction

    function automatic logic orphan();
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_LINES; i++)
            if (own_vld[i] && !open_q[own_flat[i*TID_W +: TID_W]]) r = 1'b1;
        return r;
    endfunction

    assert_one_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid && rsp_tid == $past(req_tid));
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    assert_commit_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2) |=> rsp_kind == 2'd2 && !owned_in(tid_bit($past(req_tid))));
    assert_abort_cmd_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd3) |=> rsp_kind == 2'd3 && !owned_in(tid_bit(rsp_tid)));
    assert_loser_released_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd3) |-> !kill_valid && !owned_in(tid_bit(rsp_tid)));
    assert_victim_R8: assert property (@(posedge clk) disable iff (rst)
        kill_valid |-> rsp_valid && kill_tid != rsp_tid && !owned_in(tid_bit(kill_tid)));
    assert_owner_open_R9: assert property (@(posedge clk) disable iff (rst)
        !orphan());
    assert_fail_release_R10: assert property (@(posedge clk) disable iff (rst)
        fail_valid |=> !owned_in(pe_mask($past(fail_pe))) && !rsp_valid);
endmodule

bind txn_line_owner txn_owner_checker u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_tid(req_tid),
    .fail_valid(fail_valid), .fail_pe(fail_pe), .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind), .rsp_tid(rsp_tid), .kill_valid(kill_valid),
    .kill_tid(kill_tid), .own_vld(own_vld_w), .own_flat(own_flat_w), .open_q(open_w)
);

// File: tb/tb_txn_line_owner.sv
module tb_txn_line_owner;
    import txn_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [TID_W-1:0] req_tid = '0;
    logic [LINE_W-1:0] req_line = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic fail_valid = 1'b0;
    logic [PE_W-1:0] fail_pe = '0;
    logic rsp_valid;
    logic [1:0] rsp_kind;
    logic [TID_W-1:0] rsp_tid;
    logic [DATA_W-1:0] rsp_data;
    logic kill_valid;
    logic [TID_W-1:0] kill_tid;

    always #10 clk = ~clk;

    txn_line_owner dut (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [DATA_W-1:0] m_act [NUM_LINES];
    logic [DATA_W-1:0] m_upd [NUM_LINES];
    bit m_ov [NUM_LINES];
    int m_ot [NUM_LINES];
    bit m_open [NUM_TX];
    int m_seq [NUM_TX];
    int m_ctr = 0;
    int last_kind;

    task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] rand_line();
        logic [DATA_W-1:0] v;
        for (int w = 0; w < DATA_W / 32; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic m_release(int t);
        for (int l = 0; l < NUM_LINES; l++)
            if (m_ov[l] && m_ot[l] == t) m_ov[l] = 0;
        m_open[t] = 0;
    endtask

    task automatic apply(int op, int tid, int line, logic [DATA_W-1:0] wd);
        int ek = 0, rseq;
        bit ekill = 0;
        int ektid = 0;
        logic [DATA_W-1:0] ed = '0;
        string tag = "R2 R11";
        if (op < 2) begin
            rseq = m_open[tid] ? m_seq[tid] : m_ctr;
            if (m_ov[line] && m_ot[line] != tid) begin
                if (rseq > m_seq[m_ot[line]]) begin
                    ek = 3; tag = "R7"; m_release(tid);
                end else begin
                    ekill = 1; ektid = m_ot[line]; tag = "R8"; m_release(m_ot[line]);
                end
            end
            if (ek != 3) begin
                if (!m_open[tid]) begin m_open[tid] = 1; m_seq[tid] = m_ctr; m_ctr++; end
                if (!(m_ov[line] && m_ot[line] == tid)) begin
                    m_upd[line] = m_act[line]; m_ov[line] = 1; m_ot[line] = tid;
                    if (tag == "R2 R11") tag = "R3";
                end else if (tag == "R2 R11") tag = "R4";
                if (op == 1) begin m_upd[line] = wd; ek = 2; end
                else begin ek = 1; ed = m_upd[line]; end
            end
        end else if (op == 2) begin
            for (int l = 0; l < NUM_LINES; l++)
                if (m_ov[l] && m_ot[l] == tid) begin m_act[l] = m_upd[l]; m_ov[l] = 0; end
            m_open[tid] = 0; ek = 2; tag = "R5";
        end else begin
            m_release(tid); ek = 3; tag = "R6";
        end
        @(negedge clk);
        req_valid = 1; req_op = 2'(op); req_tid = TID_W'(tid);
        req_line = LINE_W'(line); req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " valid"}, DATA_W'(rsp_valid), DATA_W'(1));
        chk({tag, " kind"}, DATA_W'(rsp_kind), DATA_W'(ek));
        chk({tag, " tid"}, DATA_W'(rsp_tid), DATA_W'(tid));
        if (ek == 1) chk({tag, " data"}, rsp_data, ed);
        chk({tag, " kill"}, DATA_W'(kill_valid), DATA_W'(ekill));
        if (ekill) chk({tag, " kill_tid"}, DATA_W'(kill_tid), DATA_W'(ektid));
        last_kind = int'(rsp_kind);
    endtask

    task automatic do_fail(int pe);
        @(negedge clk);
        fail_valid = 1; fail_pe = PE_W'(pe);
        @(negedge clk);
        fail_valid = 0;
        chk("R10 no response", DATA_W'(rsp_valid), DATA_W'(0));
        for (int t = 0; t < NUM_TX; t++)
            if (t / TX_PER_PE == pe) m_release(t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] da, db;
        void'($urandom(32'd20081212));
        for (int l = 0; l < NUM_LINES; l++) begin m_act[l] = '0; m_upd[l] = '0; m_ov[l] = 0; m_ot[l] = 0; end
        for (int t = 0; t < NUM_TX; t++) begin m_open[t] = 0; m_seq[t] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk("R1 rsp_valid", DATA_W'(rsp_valid), DATA_W'(0));
        chk("R1 kill_valid", DATA_W'(kill_valid), DATA_W'(0));
        apply(0, 0, 3, '0);
        chk("R1 zero line", rsp_data, '0);
        apply(3, 0, 0, '0);

        da = rand_line(); db = rand_line();
        apply(1, 0, 1, da);
        apply(0, 0, 1, '0);
        chk("R4 own write seen", rsp_data, da);
        apply(0, 1, 1, '0);
        chk("R7 younger aborted", DATA_W'(last_kind), DATA_W'(3));
        apply(2, 0, 0, '0);
        apply(0, 1, 1, '0);
        chk("R5 committed data", rsp_data, da);
        apply(2, 1, 0, '0);

        apply(1, 2, 2, db);
        apply(1, 3, 6, da);
        apply(0, 2, 6, '0);
        chk("R8 owner killed", DATA_W'(kill_valid), DATA_W'(1));
        apply(3, 2, 0, '0);
        apply(0, 0, 2, '0);
        chk("R6 update dropped", rsp_data, '0);
        apply(2, 0, 0, '0);

        apply(1, 1, 8, da);
        apply(1, 0, 9, db);
        apply(0, 0, 8, '0);
        chk("R9 reopened is younger", DATA_W'(last_kind), DATA_W'(3));
        apply(2, 1, 0, '0);

        apply(1, 3, 7, db);
        do_fail(1);
        apply(0, 0, 7, '0);
        chk("R10 failed write gone", rsp_data, '0);
        apply(2, 0, 0, '0);

        for (int i = 0; i < 400; i++) begin
            int r, tid, line;
            r = $urandom % 100;
            tid = $urandom % NUM_TX;
            line = ($urandom % 4 == 0) ? ($urandom % NUM_LINES) : ($urandom % 4);
            if (r < 40)      apply(0, tid, line, '0);
            else if (r < 75) apply(1, tid, line, rand_line());
            else if (r < 88) apply(2, tid, 0, '0);
            else if (r < 95) apply(3, tid, 0, '0);
            else             do_fail($urandom % NUM_PE);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule